// File: doc/BRIEF.md
# Dual-Class Interrupt Controller Register Block

This block collects forty level-sensitive interrupt sources into two banks. The low bank holds sources 0 to 31 and the high bank holds sources 32 to 39. Every source has an enable bit and a class bit. The class bit sends an enabled source to the fast interrupt line (`fiq_o`) when set, or to the normal line (`irq_o`) when clear. A wake line tells an idle processor that a source needs attention. An idle-control bit chooses between two wake rules: only enabled sources may wake, or any pending source may wake even when it is masked.

Software uses a 32-bit register port with word addresses. It can read the raw pending bits, the pending bits filtered by mask and class, the mask, the class and the idle control. It can write the mask, the class, the idle control and forty priority entries. The winner of the priority lookup is computed outside this block. That value comes in on `hp_i`, and the block returns it at its own offset.

Top module: `intc_regs`

## Requirements
- R1: Each pending bit follows its source input. It takes the input level on the next rising clock edge. Raw pending reads at 0x10 return sources 31:0. Raw pending reads at 0xAC return sources 39:32 in bits 7:0, with the upper bits reading zero.
- R2: Reads at 0x00 (low) and 0x9C (high) return pending AND mask AND NOT class. Reads at 0x0C (low) and 0xA8 (high) return pending AND mask AND class.
- R3: The mask registers (0x04 low, 0xA0 high) and the class registers (0x08 low, 0xA4 high) are written and read back. A high-bank register keeps only bits 7:0 and reads zero above them.
- R4: `fiq_o` is high when at least one pending, enabled source has its class bit set. `irq_o` is high when at least one pending, enabled source has its class bit clear. Both outputs follow the clock edge that updates the pending, mask or class state.
- R5: Control register 0x14 stores bit 0 of a write and returns it in bit 0 of a read. All other bits read as zero.
- R6: `wake_o` is high only while `idle_i` is high and some pending source is either enabled or released by the idle rule. With control bit 0 = 1 only enabled sources count. With control bit 0 = 0 every pending source counts.
- R7: Priority entry k (0..31) is at 0x1C+4k, and entry k (32..39) is at 0xB0+4(k-32). A write keeps bit 31 and bits 5:0 of the data. Every other bit reads zero.
- R8: A read at 0x18 returns `hp_i` unchanged.
- R9: A read at an offset above 0xCC, or at an address that is not word aligned, returns zero. A write to a read-only or unmapped offset changes no state.
- R10: Reset clears mask, class, pending and every priority entry. It sets control bit 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Interrupt source levels, high = requesting |
| idle_i | input | 1 | Processor is idle |
| hp_i | input | 32 | Result from the external priority resolver |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake from idle |

## Verification
The assertions make three assumptions about the inputs. The address, write strobe and write data hold steady around each rising edge. The source levels are sampled at that edge only. Reset is released between edges, so the first sampled cycle after reset already loads pending from the sources. The stimulus meets all three by changing every input on the falling clock edge and releasing reset there. No source or write is ever launched at the rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned N_SRC  = 40;
  localparam int unsigned LO_W   = 32;
  localparam int unsigned HI_W   = N_SRC - LO_W;
  localparam int unsigned PIDX_W = $clog2(N_SRC);
  localparam int unsigned ID_W   = 6;
  localparam int unsigned AW     = 8;

  localparam logic [AW-1:0] A_IRQ_LO  = 8'h00;
  localparam logic [AW-1:0] A_MSK_LO  = 8'h04;
  localparam logic [AW-1:0] A_CLS_LO  = 8'h08;
  localparam logic [AW-1:0] A_FIQ_LO  = 8'h0C;
  localparam logic [AW-1:0] A_RAW_LO  = 8'h10;
  localparam logic [AW-1:0] A_CTRL    = 8'h14;
  localparam logic [AW-1:0] A_HP      = 8'h18;
  localparam logic [AW-1:0] A_PRI_LO0 = 8'h1C;
  localparam logic [AW-1:0] A_PRI_LO1 = 8'h98;
  localparam logic [AW-1:0] A_IRQ_HI  = 8'h9C;
  localparam logic [AW-1:0] A_MSK_HI  = 8'hA0;
  localparam logic [AW-1:0] A_CLS_HI  = 8'hA4;
  localparam logic [AW-1:0] A_FIQ_HI  = 8'hA8;
  localparam logic [AW-1:0] A_RAW_HI  = 8'hAC;
  localparam logic [AW-1:0] A_PRI_HI0 = 8'hB0;
  localparam logic [AW-1:0] A_PRI_HI1 = 8'hCC;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         msk_we_i,
  input  logic         cls_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] msk_o,
  output logic [W-1:0] cls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      msk_o  <= '0;
      cls_o  <= '0;
    end else begin
      pend_o <= src_i;
      if (msk_we_i) msk_o <= wdata_i;
      if (cls_we_i) cls_o <= wdata_i;
    end
  end
endmodule

// File: rtl/intc_prio_table.sv
module intc_prio_table #(
  parameter int unsigned N    = 40,
  parameter int unsigned ID_W = 6,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned EW  = ID_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [31:0]   rdata_o
);
  logic [EW-1:0] ent_q [N];

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q[k] <= '0;
      else if (we_i && widx_i == IW'(k))         ent_q[k] <= {wdata_i[31], wdata_i[ID_W-1:0]};
    end
  end

  logic [EW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int k = 0; k < N; k++)
      if (ridx_i == IW'(k)) sel = ent_q[k];
  end

  assign rdata_o = {sel[EW-1], {(31-ID_W){1'b0}}, sel[ID_W-1:0]};
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   src_i,
  input  logic               idle_i,
  input  logic [31:0]        hp_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  logic [N_SRC-1:0] pend_all, mask_all, cls_all;
  logic             only_en_q;

  // bank select: 0 = low, 1 = high
  logic [1:0] msk_we, cls_we;
  assign msk_we[0] = wr_i && addr_i == A_MSK_LO;
  assign msk_we[1] = wr_i && addr_i == A_MSK_HI;
  assign cls_we[0] = wr_i && addr_i == A_CLS_LO;
  assign cls_we[1] = wr_i && addr_i == A_CLS_HI;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int unsigned BW = (b == 0) ? LO_W : HI_W;
    localparam int unsigned LB = (b == 0) ? 0 : LO_W;
    intc_bank #(.W(BW)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[LB +: BW]),
      .msk_we_i (msk_we[b]),
      .cls_we_i (cls_we[b]),
      .wdata_i  (wdata_i[BW-1:0]),
      .pend_o   (pend_all[LB +: BW]),
      .msk_o    (mask_all[LB +: BW]),
      .cls_o    (cls_all[LB +: BW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     only_en_q <= 1'b1;
    else if (wr_i && addr_i == A_CTRL) only_en_q <= wdata_i[0];
  end

  // priority address decode
  logic [AW-1:0]     off_lo, off_hi;
  logic              in_pri_lo, in_pri_hi, aligned;
  logic [PIDX_W-1:0] pidx;
  assign off_lo    = addr_i - A_PRI_LO0;
  assign off_hi    = addr_i - A_PRI_HI0;
  assign aligned   = addr_i[1:0] == 2'b00;
  assign in_pri_lo = aligned && addr_i >= A_PRI_LO0 && addr_i <= A_PRI_LO1;
  assign in_pri_hi = aligned && addr_i >= A_PRI_HI0 && addr_i <= A_PRI_HI1;
  assign pidx      = in_pri_hi ? PIDX_W'(LO_W) + PIDX_W'(off_hi[AW-1:2])
                               : PIDX_W'(off_lo[AW-1:2]);

  logic [31:0] pri_rd;
  intc_prio_table #(.N(N_SRC), .ID_W(ID_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && (in_pri_lo || in_pri_hi)),
    .widx_i  (pidx),
    .wdata_i (wdata_i),
    .ridx_i  (pidx),
    .rdata_o (pri_rd)
  );

  logic [N_SRC-1:0] act, irq_vec, fiq_vec;
  assign act     = pend_all & mask_all;
  assign irq_vec = act & ~cls_all;
  assign fiq_vec = act & cls_all;

  assign irq_o  = |irq_vec;
  assign fiq_o  = |fiq_vec;
  assign wake_o = idle_i && |(pend_all & (mask_all | {N_SRC{~only_en_q}}));

  always_comb begin
    rdata_o = '0;
    if (in_pri_lo || in_pri_hi) rdata_o = pri_rd;
    else begin
      unique case (addr_i)
        A_IRQ_LO: rdata_o = irq_vec[LO_W-1:0];
        A_FIQ_LO: rdata_o = fiq_vec[LO_W-1:0];
        A_MSK_LO: rdata_o = mask_all[LO_W-1:0];
        A_CLS_LO: rdata_o = cls_all[LO_W-1:0];
        A_RAW_LO: rdata_o = pend_all[LO_W-1:0];
        A_CTRL:   rdata_o = {31'b0, only_en_q};
        A_HP:     rdata_o = hp_i;
        A_IRQ_HI: rdata_o = 32'(irq_vec[N_SRC-1:LO_W]);
        A_FIQ_HI: rdata_o = 32'(fiq_vec[N_SRC-1:LO_W]);
        A_MSK_HI: rdata_o = 32'(mask_all[N_SRC-1:LO_W]);
        A_CLS_HI: rdata_o = 32'(cls_all[N_SRC-1:LO_W]);
        A_RAW_HI: rdata_o = 32'(pend_all[N_SRC-1:LO_W]);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_regs_chk.sv
module intc_regs_chk
  import intc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic             idle_i,
  input logic [AW-1:0]    addr_i,
  input logic             wr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             wake_o,
  input logic [N_SRC-1:0] pend_all,
  input logic [N_SRC-1:0] mask_all
);
  AST_PEND_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_all == $past(src_i)); // R1
  AST_IRQ_READ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_IRQ_LO && rdata_o != 0) |-> irq_o); // R2
  AST_FIQ_READ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_FIQ_HI && rdata_o != 0) |-> fiq_o); // R4
  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MSK_LO) |=> mask_all[LO_W-1:0] == $past(wdata_i)); // R3
  AST_WAKE_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !wake_o); // R6
  AST_PRIO_ZERO_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] == 2'b00 && addr_i >= A_PRI_HI0 && addr_i <= A_PRI_HI1) |-> rdata_o[30:6] == 0); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > A_PRI_HI1 || addr_i[1:0] != 2'b00) |-> rdata_o == 0); // R9
endmodule

bind intc_regs intc_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .idle_i   (idle_i),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .wake_o   (wake_o),
  .pend_all (pend_all),
  .mask_all (mask_all)
);

// File: tb/tb_intc_regs.sv
module tb_intc_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] src_i = '0;
  logic        idle_i = 1'b0;
  logic [31:0] hp_i = '0;
  logic [7:0]  addr_i = 8'hFC;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o, wake_o;

  intc_regs dut (.*);

  always #10 clk_i = ~clk_i;

  typedef enum int {K_RD, K_IRQ, K_FIQ, K_WAKE} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic push(kind_e k, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    push(K_RD, e, t);
  endtask

  task automatic line(kind_e k, logic e, string t);
    @(negedge clk_i);
    addr_i = 8'hFC; wr_i = 1'b0;
    push(k, {31'b0, e}, t);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = 8'hFC;
  endtask

  task automatic set_src(logic [39:0] v);
    @(negedge clk_i);
    src_i = v;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = rdata_o;
          K_IRQ:   act = {31'b0, irq_o};
          K_FIQ:   act = {31'b0, fiq_o};
          default: act = {31'b0, wake_o};
        endcase
        vecs++;
        if (act !== it.exp) begin
          errs++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    rd(8'h04, 32'h0, "R10 mask lo");
    rd(8'hA4, 32'h0, "R10 class hi");
    rd(8'h14, 32'h1, "R10 ctrl");
    rd(8'h1C, 32'h0, "R10 prio0");
    line(K_IRQ, 1'b0, "R10 irq");
    // R1 raw pending
    set_src({8'h81, 32'h0000_00F0});
    rd(8'h10, 32'h0000_00F0, "R1 raw lo");
    rd(8'hAC, 32'h0000_0081, "R1 raw hi");
    line(K_IRQ, 1'b0, "R4 masked irq");
    // R2 R3 R4 class routing
    wr(8'h04, 32'h0000_0030);
    wr(8'h08, 32'h0000_0020);
    wr(8'hA0, 32'h0000_0080);
    rd(8'h04, 32'h0000_0030, "R3 mask lo");
    rd(8'h00, 32'h0000_0010, "R2 irq pend lo");
    rd(8'h0C, 32'h0000_0020, "R2 fiq pend lo");
    rd(8'h9C, 32'h0000_0080, "R2 irq pend hi");
    rd(8'hA8, 32'h0000_0000, "R2 fiq pend hi");
    line(K_IRQ, 1'b1, "R4 irq");
    line(K_FIQ, 1'b1, "R4 fiq");
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, 32'h0000_00FF, "R3 mask hi width");
    set_src({8'h00, 32'h0000_0010});
    line(K_FIQ, 1'b0, "R4 fiq drop");
    line(K_IRQ, 1'b1, "R4 irq stays");
    set_src('0);
    line(K_IRQ, 1'b0, "R4 irq drop");
    // R5 R6 wake
    idle_i = 1'b1;
    set_src({8'h00, 32'h0000_0001});
    line(K_WAKE, 1'b0, "R6 only enabled");
    wr(8'h14, 32'hFFFF_FFFE);
    rd(8'h14, 32'h0, "R5 ctrl clear");
    line(K_WAKE, 1'b1, "R6 any pending");
    @(negedge clk_i); idle_i = 1'b0;
    line(K_WAKE, 1'b0, "R6 not idle");
    wr(8'h14, 32'h0000_0001);
    rd(8'h14, 32'h1, "R5 ctrl set");
    // R7 priority
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h8000_003F, "R7 prio0 mask");
    wr(8'hCC, 32'h7FFF_FFC5);
    rd(8'hCC, 32'h0000_0005, "R7 prio39");
    rd(8'h98, 32'h0000_0000, "R7 prio31 untouched");
    wr(8'hB0, 32'h8000_0027);
    rd(8'hB0, 32'h8000_0027, "R7 prio32");
    // R8
    hp_i = 32'h1234_5678;
    rd(8'h18, 32'h1234_5678, "R8 hp");
    // R9
    set_src({8'h00, 32'h0000_0010});
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0030, "R9 mask kept");
    rd(8'h08, 32'h0000_0020, "R9 class kept");
    rd(8'h10, 32'h0000_0010, "R9 raw kept");
    rd(8'hD0, 32'h0, "R9 unmapped rd");
    rd(8'h05, 32'h0, "R9 unaligned rd");
    // R10 mid-run reset
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1; src_i = '0;
    rd(8'h04, 32'h0, "R10 mask after reset");
    rd(8'h1C, 32'h0, "R10 prio after reset");
    rd(8'h14, 32'h1, "R10 ctrl after reset");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule